// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block caches virtual-to-physical page mappings in a small, fully associative array. Each slot holds a virtual page tag, a physical base, its own page-size exponent, and four attribute bits: global, writable, user-accessible and uncached. A lookup compares the virtual address against every slot at once. Only the bits at or above each slot's own exponent take part in the compare. The result comes out one cycle later: hit, physical address, uncached flag and a protection fault.

Software or a page walker fills the array through an insert port. When no slot is free, the slot with the oldest recency stamp is replaced. Stamps come from one running counter. A slot takes a fresh stamp when it is filled, and on a lookup hit only when the lookup asks for recency to be refreshed. Three maintenance commands remove mappings: drop everything, drop every non-global mapping, and drop the one mapping that covers a given address.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is free. No lookup hits until an insert has been made, and before the first lookup `lk_done_o` and `lk_hit_o` are 0.
- R2: A lookup presented in cycle N returns its result with `lk_done_o`=1 after the clock edge that ends cycle N. It sees the array as it stood before any insert, flush or invalidate applied in that same cycle.
- R3: On a hit, `lk_paddr_o` is the slot's physical base OR'd with the address bits below the slot's exponent `ins_shift_i`. The tag compare ignores those low bits. On a miss, hit, fault and uncached are 0 and the address is 0. `lk_uncached_o` reflects the slot's uncached bit.
- R4: Inserts fill free slots before any valid slot is evicted, so NUM_ENTRIES distinct pages inserted into an empty array all hit.
- R5: An insert with no free slot replaces the slot with the smallest recency stamp. A lookup with `lk_touch_i`=1 that hits gives its slot a new, largest stamp.
- R6: A lookup with `lk_touch_i`=0 leaves the recency stamps unchanged.
- R7: An insert whose address already hits a valid slot changes nothing: the existing mapping is kept, no slot is allocated and no slot is evicted.
- R8: `flush_all_i` frees every slot.
- R9: `flush_local_i` frees only the slots whose global bit is 0.
- R10: `inval_valid_i` frees the slot that matches `inval_vaddr_i`, if any. Other slots are not affected.
- R11: An access is user-level when `lk_priv_i`==3 and `lk_force_sup_i`==0. A user-level hit on a slot whose user bit is 0 faults, and `lk_fault_write_o` then equals `lk_write_i`.
- R12: Writes are illegal on a slot that is not writable when the access is user-level or `lk_wp_i`=1. A write hit on such a slot faults with `lk_fault_write_o`=1.
- R13: A lookup with `lk_store_probe_i`=1 that hits a slot where writes are illegal faults with `lk_fault_write_o`=1, even when `lk_write_i`=0.
- R14: Only one maintenance action applies per cycle, in this order of precedence: `flush_all_i`, `flush_local_i`, `inval_valid_i`, insert. A lower-ranked request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Lookup virtual address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_store_probe_i | input | 1 | Check write permission without writing |
| lk_priv_i | input | 2 | Privilege level, 3 is least privileged |
| lk_force_sup_i | input | 1 | Treat the access as supervisor |
| lk_wp_i | input | 1 | Enforce write protection for supervisor |
| lk_touch_i | input | 1 | Refresh recency of the hit slot |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | PA_W | Translated physical address |
| lk_uncached_o | output | 1 | Hit slot is uncached |
| lk_fault_o | output | 1 | Protection fault |
| lk_fault_write_o | output | 1 | Fault reported as a write |
| ins_valid_i | input | 1 | Insert request |
| ins_vaddr_i | input | VA_W | Insert virtual address |
| ins_pbase_i | input | PA_W | Insert physical base |
| ins_shift_i | input | SH_W | Insert page-size exponent |
| ins_global_i | input | 1 | Insert global bit |
| ins_writable_i | input | 1 | Insert writable bit |
| ins_user_i | input | 1 | Insert user bit |
| ins_uncached_i | input | 1 | Insert uncached bit |
| flush_all_i | input | 1 | Free every slot |
| flush_local_i | input | 1 | Free non-global slots |
| inval_valid_i | input | 1 | Single-page invalidate request |
| inval_vaddr_i | input | VA_W | Invalidate address |

## Verification
A corrupted stamp or a wrong victim choice does not show at once. It only shows when a later insert evicts the wrong page, and a lookup after that misses on a page that should still be present. The bench therefore sets up a known stamp order and probes every page after each eviction. A wrong valid bit or tag shows on the next lookup, one cycle after it is presented. Permission logic is exercised with each combination of privilege, force-supervisor, write-protect and probe against pages with different attributes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic glob;
    logic wr;
    logic usr;
    logic unc;
  } xlat_attr_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH_ALL,
    OP_FLUSH_LOCAL,
    OP_INVAL,
    OP_INSERT
  } xlat_op_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int VA_W = 32,
  parameter int SH_W = 5
) (
  input  logic            valid_i,
  input  logic [VA_W-1:0] tag_i,
  input  logic [SH_W-1:0] shift_i,
  input  logic [VA_W-1:0] va_i,
  output logic            hit_o
);
  logic [VA_W-1:0] low_mask;
  assign low_mask = (VA_W'(1) << shift_i) - VA_W'(1);
  assign hit_o    = valid_i && ((va_i & ~low_mask) == tag_i);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 8,
  parameter int SEQ_W = 32,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     valid_i,
  input  logic [SEQ_W-1:0] stamp_i [N],
  output logic [IDX_W-1:0] idx_o
);
  logic found_free;
  always_comb begin
    found_free = 1'b0;
    idx_o      = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_i[i] && !found_free) begin
        idx_o      = IDX_W'(i);
        found_free = 1'b1;
      end
    end
    if (!found_free) begin
      for (int i = 1; i < N; i++) begin
        if (stamp_i[i] < stamp_i[idx_o]) idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  xlat_attr_t attr_i,
  input  logic       write_i,
  input  logic       probe_i,
  input  logic [1:0] priv_i,
  input  logic       force_sup_i,
  input  logic       wp_i,
  output logic       fault_o,
  output logic       fault_write_o
);
  logic is_user, bad_write, priv_fault;
  assign is_user    = (priv_i == 2'd3) && !force_sup_i;
  assign bad_write  = !attr_i.wr && (is_user || wp_i);
  assign priv_fault = (is_user && !attr_i.usr) || (write_i && bad_write);
  assign fault_o    = priv_fault || (probe_i && bad_write);
  // the privilege fault carries the request mode; a probe fault is a write
  assign fault_write_o = priv_fault ? write_i : (probe_i && bad_write);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int SEQ_W       = 32,
  localparam int SH_W       = $clog2(VA_W),
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_valid_i,
  input  logic [VA_W-1:0] lk_vaddr_i,
  input  logic            lk_write_i,
  input  logic            lk_store_probe_i,
  input  logic [1:0]      lk_priv_i,
  input  logic            lk_force_sup_i,
  input  logic            lk_wp_i,
  input  logic            lk_touch_i,
  output logic            lk_done_o,
  output logic            lk_hit_o,
  output logic [PA_W-1:0] lk_paddr_o,
  output logic            lk_uncached_o,
  output logic            lk_fault_o,
  output logic            lk_fault_write_o,
  input  logic            ins_valid_i,
  input  logic [VA_W-1:0] ins_vaddr_i,
  input  logic [PA_W-1:0] ins_pbase_i,
  input  logic [SH_W-1:0] ins_shift_i,
  input  logic            ins_global_i,
  input  logic            ins_writable_i,
  input  logic            ins_user_i,
  input  logic            ins_uncached_i,
  input  logic            flush_all_i,
  input  logic            flush_local_i,
  input  logic            inval_valid_i,
  input  logic [VA_W-1:0] inval_vaddr_i
);
  if (NUM_ENTRIES < 1) begin : g_bad_size
    $error("xlat_cache needs at least one entry");
  end

  logic [NUM_ENTRIES-1:0] valid_q;
  logic [VA_W-1:0]        tag_q   [NUM_ENTRIES];
  logic [PA_W-1:0]        pbase_q [NUM_ENTRIES];
  logic [SH_W-1:0]        shift_q [NUM_ENTRIES];
  xlat_attr_t             attr_q  [NUM_ENTRIES];
  logic [SEQ_W-1:0]       stamp_q [NUM_ENTRIES];
  logic [SEQ_W-1:0]       seq_q;

  logic [NUM_ENTRIES-1:0] lk_vec, ins_vec, inv_vec, glob_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    xlat_match #(.VA_W(VA_W), .SH_W(SH_W)) u_lk_match (
      .valid_i(valid_q[g]), .tag_i(tag_q[g]), .shift_i(shift_q[g]),
      .va_i(lk_vaddr_i), .hit_o(lk_vec[g]));
    xlat_match #(.VA_W(VA_W), .SH_W(SH_W)) u_ins_match (
      .valid_i(valid_q[g]), .tag_i(tag_q[g]), .shift_i(shift_q[g]),
      .va_i(ins_vaddr_i), .hit_o(ins_vec[g]));
    xlat_match #(.VA_W(VA_W), .SH_W(SH_W)) u_inv_match (
      .valid_i(valid_q[g]), .tag_i(tag_q[g]), .shift_i(shift_q[g]),
      .va_i(inval_vaddr_i), .hit_o(inv_vec[g]));
    assign glob_vec[g] = attr_q[g].glob;
  end

  // lowest index wins when page sizes overlap
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  always_comb begin
    lk_any = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lk_vec[i] && !lk_any) begin
        lk_any = 1'b1;
        lk_idx = IDX_W'(i);
      end
    end
  end

  logic [IDX_W-1:0] victim_idx;
  xlat_victim #(.N(NUM_ENTRIES), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_victim (
    .valid_i(valid_q), .stamp_i(stamp_q), .idx_o(victim_idx));

  xlat_attr_t lk_attr;
  logic       perm_fault, perm_fault_wr;
  assign lk_attr = attr_q[lk_idx];
  xlat_perm u_perm (
    .attr_i(lk_attr), .write_i(lk_write_i), .probe_i(lk_store_probe_i),
    .priv_i(lk_priv_i), .force_sup_i(lk_force_sup_i), .wp_i(lk_wp_i),
    .fault_o(perm_fault), .fault_write_o(perm_fault_wr));

  logic [VA_W-1:0] lk_low_mask;
  logic [PA_W-1:0] lk_paddr;
  assign lk_low_mask = (VA_W'(1) << shift_q[lk_idx]) - VA_W'(1);
  assign lk_paddr    = pbase_q[lk_idx] | PA_W'(lk_vaddr_i & lk_low_mask);

  xlat_op_e op;
  always_comb begin
    if (flush_all_i)                      op = OP_FLUSH_ALL;
    else if (flush_local_i)               op = OP_FLUSH_LOCAL;
    else if (inval_valid_i)               op = OP_INVAL;
    else if (ins_valid_i && ~|ins_vec)    op = OP_INSERT;
    else                                  op = OP_NONE;
  end

  logic            do_touch;
  logic [SEQ_W-1:0] ins_stamp;
  logic [VA_W-1:0]  ins_low_mask;
  assign do_touch     = lk_valid_i && lk_touch_i && lk_any;
  assign ins_stamp    = seq_q + SEQ_W'(do_touch);
  assign ins_low_mask = (VA_W'(1) << ins_shift_i) - VA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      seq_q   <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tag_q[i]   <= '0;
        pbase_q[i] <= '0;
        shift_q[i] <= '0;
        attr_q[i]  <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      if (do_touch) stamp_q[lk_idx] <= seq_q;
      seq_q <= ins_stamp + SEQ_W'(op == OP_INSERT);
      case (op)
        OP_FLUSH_ALL:   valid_q <= '0;
        OP_FLUSH_LOCAL: valid_q <= valid_q & glob_vec;
        OP_INVAL:       valid_q <= valid_q & ~inv_vec;
        OP_INSERT: begin
          valid_q[victim_idx] <= 1'b1;
          tag_q[victim_idx]   <= ins_vaddr_i & ~ins_low_mask;
          pbase_q[victim_idx] <= ins_pbase_i;
          shift_q[victim_idx] <= ins_shift_i;
          attr_q[victim_idx]  <= '{glob: ins_global_i, wr: ins_writable_i,
                                   usr: ins_user_i, unc: ins_uncached_i};
          stamp_q[victim_idx] <= ins_stamp;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o        <= 1'b0;
      lk_hit_o         <= 1'b0;
      lk_paddr_o       <= '0;
      lk_uncached_o    <= 1'b0;
      lk_fault_o       <= 1'b0;
      lk_fault_write_o <= 1'b0;
    end else begin
      lk_done_o        <= lk_valid_i;
      lk_hit_o         <= lk_valid_i && lk_any;
      lk_paddr_o       <= (lk_valid_i && lk_any) ? lk_paddr : '0;
      lk_uncached_o    <= lk_valid_i && lk_any && lk_attr.unc;
      lk_fault_o       <= lk_valid_i && lk_any && perm_fault;
      lk_fault_write_o <= lk_valid_i && lk_any && perm_fault_wr;
    end
  end

  AST_DONE_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_done_o); // R2
  AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0)); // R8
  AST_FLUSH_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_local_i && !flush_all_i) |=> (valid_q == $past(valid_q & glob_vec))); // R9
  AST_DUP_INSERT_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && |ins_vec && !flush_all_i && !flush_local_i && !inval_valid_i)
      |=> $stable(valid_q)); // R7
  AST_MISS_IS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (!lk_fault_o && !lk_uncached_o && lk_paddr_o == '0)); // R3
  AST_FAULT_WRITE_NEEDS_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_write_o |-> lk_fault_o); // R13
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 4;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int SH_W = $clog2(VA_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            lk_valid = 0, lk_write = 0, lk_probe = 0, lk_fsup = 0, lk_wp = 0, lk_touch = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic [1:0]      lk_priv = '0;
  logic            done, hit, unc, fault, fw;
  logic [PA_W-1:0] pa;
  logic            ins_valid = 0, ins_g = 0, ins_w = 0, ins_u = 0, ins_c = 0;
  logic [VA_W-1:0] ins_va = '0;
  logic [PA_W-1:0] ins_pb = '0;
  logic [SH_W-1:0] ins_sh = '0;
  logic            fl_all = 0, fl_loc = 0, inv_valid = 0;
  logic [VA_W-1:0] inv_va = '0;

  xlat_cache #(.NUM_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_va), .lk_write_i(lk_write),
    .lk_store_probe_i(lk_probe), .lk_priv_i(lk_priv), .lk_force_sup_i(lk_fsup),
    .lk_wp_i(lk_wp), .lk_touch_i(lk_touch),
    .lk_done_o(done), .lk_hit_o(hit), .lk_paddr_o(pa), .lk_uncached_o(unc),
    .lk_fault_o(fault), .lk_fault_write_o(fw),
    .ins_valid_i(ins_valid), .ins_vaddr_i(ins_va), .ins_pbase_i(ins_pb),
    .ins_shift_i(ins_sh), .ins_global_i(ins_g), .ins_writable_i(ins_w),
    .ins_user_i(ins_u), .ins_uncached_i(ins_c),
    .flush_all_i(fl_all), .flush_local_i(fl_loc),
    .inval_valid_i(inv_valid), .inval_vaddr_i(inv_va));

  typedef struct {
    logic            hit;
    logic [PA_W-1:0] pa;
    logic            unc;
    logic            fault;
    logic            fw;
    string           req;
  } exp_t;

  exp_t exp_q[$];
  int n_vec = 0;
  int n_bad = 0;

  // monitor: pops one expectation per completed lookup
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected result: actual done=1 expected done=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (hit !== e.hit || pa !== e.pa || unc !== e.unc || fault !== e.fault || fw !== e.fw) begin
          n_bad++;
          $display("FAIL %s: actual hit=%0b pa=%h unc=%0b fault=%0b fw=%0b expected hit=%0b pa=%h unc=%0b fault=%0b fw=%0b",
                   e.req, hit, pa, unc, fault, fw, e.hit, e.pa, e.unc, e.fault, e.fw);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lk_valid = 0; lk_write = 0; lk_probe = 0; lk_fsup = 0; lk_wp = 0; lk_touch = 0; lk_priv = 0;
    ins_valid = 0; fl_all = 0; fl_loc = 0; inv_valid = 0;
  endtask

  task automatic set_look(input logic [VA_W-1:0] va, input logic wr, input logic pr,
                          input logic [1:0] pv, input logic fs, input logic wp, input logic tch,
                          input logic e_hit, input logic [PA_W-1:0] e_pa, input logic e_unc,
                          input logic e_fault, input logic e_fw, input string req);
    exp_t e;
    lk_valid = 1; lk_va = va; lk_write = wr; lk_probe = pr; lk_priv = pv;
    lk_fsup = fs; lk_wp = wp; lk_touch = tch;
    e.hit = e_hit; e.pa = e_pa; e.unc = e_unc; e.fault = e_fault; e.fw = e_fw; e.req = req;
    exp_q.push_back(e);
  endtask

  // plain supervisor read, no recency refresh
  task automatic look(input logic [VA_W-1:0] va, input logic e_hit,
                      input logic [PA_W-1:0] e_pa, input logic e_unc, input string req);
    set_look(va, 0, 0, 2'd0, 0, 0, 0, e_hit, e_pa, e_unc, 0, 0, req);
    step();
  endtask

  task automatic set_ins(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pb,
                         input logic [SH_W-1:0] sh, input logic g, input logic w,
                         input logic u, input logic c);
    ins_valid = 1; ins_va = va; ins_pb = pb; ins_sh = sh;
    ins_g = g; ins_w = w; ins_u = u; ins_c = c;
  endtask

  task automatic ins(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pb,
                     input logic [SH_W-1:0] sh, input logic g, input logic w,
                     input logic u, input logic c);
    set_ins(va, pb, sh, g, w, u, c);
    step();
  endtask

  task automatic inval(input logic [VA_W-1:0] va);
    inv_valid = 1; inv_va = va;
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || hit !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual done=%0b hit=%0b expected 0 0", done, hit);
    end
    look(32'h0000_1000, 0, '0, 0, "R1 empty after reset");

    // A: 4K page, writable, user
    ins(32'h0000_1000, 32'h8000_0000, 5'd12, 0, 1, 1, 0);
    look(32'h0000_1234, 1, 32'h8000_0234, 0, "R3 4K offset");
    look(32'h0000_2234, 0, '0, 0, "R3 neighbour page misses");
    // B: 4M page, global, uncached
    ins(32'h0040_0000, 32'h1000_0000, 5'd22, 1, 1, 1, 1);
    look(32'h0045_6789, 1, 32'h1005_6789, 1, "R3 large page offset");
    // C: supervisor only, read only
    ins(32'h0000_3000, 32'h9000_0000, 5'd12, 0, 0, 0, 0);
    // D: writable user
    ins(32'h0000_4000, 32'hA000_0000, 5'd12, 0, 1, 1, 0);

    set_look(32'h3010, 0, 0, 2'd3, 0, 0, 0, 1, 32'h9000_0010, 0, 1, 0, "R11 user read on supervisor page");
    step();
    set_look(32'h3010, 1, 0, 2'd3, 0, 0, 0, 1, 32'h9000_0010, 0, 1, 1, "R11 user write reports write");
    step();
    set_look(32'h3010, 0, 0, 2'd3, 1, 0, 0, 1, 32'h9000_0010, 0, 0, 0, "R11 forced supervisor");
    step();
    set_look(32'h3010, 1, 0, 2'd0, 0, 0, 0, 1, 32'h9000_0010, 0, 0, 0, "R12 supervisor write no wp");
    step();
    set_look(32'h3010, 1, 0, 2'd0, 0, 1, 0, 1, 32'h9000_0010, 0, 1, 1, "R12 supervisor write with wp");
    step();
    set_look(32'h4010, 1, 0, 2'd3, 0, 1, 0, 1, 32'hA000_0010, 0, 0, 0, "R12 user write on writable page");
    step();
    set_look(32'h3010, 0, 1, 2'd0, 0, 1, 0, 1, 32'h9000_0010, 0, 1, 1, "R13 probe with wp");
    step();
    set_look(32'h3010, 0, 1, 2'd0, 0, 0, 0, 1, 32'h9000_0010, 0, 0, 0, "R13 probe without wp");
    step();

    // duplicate insert: mapping kept, nothing evicted
    ins(32'h0000_1FFF, 32'hBBBB_0000, 5'd12, 0, 1, 1, 0);
    look(32'h0000_1004, 1, 32'h8000_0004, 0, "R7 existing mapping kept");
    look(32'h0040_0000, 1, 32'h1000_0000, 1, "R7 nothing evicted B");
    look(32'h0000_3000, 1, 32'h9000_0000, 0, "R7 nothing evicted C");
    look(32'h0000_4000, 1, 32'hA000_0000, 0, "R7 nothing evicted D");

    // refresh A, then E evicts oldest (B)
    set_look(32'h1008, 0, 0, 2'd0, 0, 0, 1, 1, 32'h8000_0008, 0, 0, 0, "R5 touch A");
    step();
    ins(32'h0000_5000, 32'hC000_0000, 5'd12, 0, 1, 1, 0);
    look(32'h0040_0000, 0, '0, 0, "R5 oldest B evicted");
    look(32'h0000_1000, 1, 32'h8000_0000, 0, "R5 touched A kept");
    look(32'h0000_5000, 1, 32'hC000_0000, 0, "R5 new E hits");
    // C was looked up many times without touch: still oldest
    ins(32'h0000_6000, 32'hD000_0000, 5'd12, 0, 1, 1, 0);
    look(32'h0000_3000, 0, '0, 0, "R6 untouched C evicted");
    look(32'h0000_4000, 1, 32'hA000_0000, 0, "R6 D kept");

    inval(32'h0000_9000);
    look(32'h0000_4000, 1, 32'hA000_0000, 0, "R10 no-match invalidate keeps D");
    look(32'h0000_6000, 1, 32'hD000_0000, 0, "R10 no-match invalidate keeps F");
    inval(32'h0000_4ABC);
    look(32'h0000_4000, 0, '0, 0, "R10 D invalidated");
    look(32'h0000_1000, 1, 32'h8000_0000, 0, "R10 A untouched");

    ins(32'h0040_0000, 32'h2000_0000, 5'd22, 1, 1, 1, 0);
    fl_loc = 1; step();
    look(32'h0041_0000, 1, 32'h2001_0000, 0, "R9 global survives");
    look(32'h0000_1000, 0, '0, 0, "R9 A flushed");
    look(32'h0000_5000, 0, '0, 0, "R9 E flushed");

    fl_all = 1;
    set_ins(32'h0000_7000, 32'hE000_0000, 5'd12, 0, 1, 1, 0);
    step();
    look(32'h0000_7000, 0, '0, 0, "R14 insert dropped under flush");
    look(32'h0040_0000, 0, '0, 0, "R8 global flushed");

    inv_valid = 1; inv_va = 32'h0000_8000;
    set_ins(32'h0000_8000, 32'hE000_0000, 5'd12, 0, 1, 1, 0);
    step();
    look(32'h0000_8000, 0, '0, 0, "R14 insert dropped under invalidate");

    set_look(32'h9000, 0, 0, 2'd0, 0, 0, 0, 0, '0, 0, 0, 0, "R2 lookup sees old state");
    set_ins(32'h0000_9000, 32'hF000_0000, 5'd12, 0, 1, 1, 0);
    step();
    look(32'h0000_9004, 1, 32'hF000_0004, 0, "R2 next lookup hits");

    ins(32'h0000_A000, 32'h0A00_0000, 5'd12, 0, 1, 1, 0);
    ins(32'h0000_B000, 32'h0B00_0000, 5'd12, 0, 1, 1, 0);
    ins(32'h0000_C000, 32'h0C00_0000, 5'd12, 0, 1, 1, 0);
    look(32'h0000_9000, 1, 32'hF000_0000, 0, "R4 fill slot 1");
    look(32'h0000_A000, 1, 32'h0A00_0000, 0, "R4 fill slot 2");
    look(32'h0000_B000, 1, 32'h0B00_0000, 0, "R4 fill slot 3");
    look(32'h0000_C000, 1, 32'h0C00_0000, 0, "R4 fill slot 4");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule